// File: doc/BRIEF.md
# Partitioned Byte-Wide Memory Decoder

This block sits between a processor's 16-bit memory access stream and two external memory paths. Every access is tagged as a code fetch or a data access. The block decides whether the access goes to a non-multiplexed byte-wide SRAM bus or falls through to the multiplexed expanded bus. For the byte-wide bus it drives two active-low chip selects, an active-low write strobe and a 15-bit address. A flag tells the surrounding bus logic which path owns the access.

The lower 32 KB window is backed by one common SRAM. That SRAM is split at a programmable boundary with a granularity of 1 KB. Below the boundary is program space, which cannot be written. At and above the boundary is data space. The boundary register starts as "everything is program" and can be rewritten at any time. A size input shrinks the decoded window to 8 KB for a small SRAM. A bank-select input moves data accesses in the window to a second, data-only SRAM. A power-fail/reset input drives all strobes to their inactive level.

Top module: `nvbd_decoder`

## Requirements
- R1: With `acc_valid` high, an access (code or data) to 0000h–7FFFh while `size_32k`=1 drives `ce1_n` low and `route_bw` high, unless R4 redirects it.
- R2: Any access with `acc_addr[15]`=1 sets `route_bw` low and holds `ce1_n`, `ce2_n` and `rw_n` high.
- R3: With `size_32k`=0, only 0000h–1FFFh decodes to `ce1_n`. Code or data accesses to 2000h–7FFFh go to the expanded bus (`route_bw`=0, both chip selects high).
- R4: With `bank2_sel`=1, data accesses to 0000h–7FFFh drive `ce2_n` low and leave `ce1_n` high, whatever `size_32k` is. Code fetches never assert `ce2_n`, and the two chip selects are never low together.
- R5: `rw_n` goes low only for a data write (`acc_code`=0, `acc_write`=1) that lands on `ce1_n` with `acc_addr[14:10]` at or above the boundary, or that lands on `ce2_n`. Writes below the boundary, code accesses and reads all leave `rw_n` high.
- R6: `bw_addr[14:13]` equals the inverse of `acc_addr[14:13]`, and `bw_addr[12:0]` equals `acc_addr[12:0]`.
- R7: While `pfail` is high or `rst_n` is low, `ce1_n`, `ce2_n` and `rw_n` are high and `route_bw` is low.
- R8: The boundary register, in KB units, resets to 32 (all program). It loads `part_val` at a rising clock edge when `part_load` is high and takes effect from the next cycle. Values above 32 saturate to 32.
- R9: Writes to the second bank are not write-protected by the boundary.
- R10: With `acc_valid` low, `ce1_n`, `ce2_n` and `rw_n` are high and `route_bw` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the boundary register |
| rst_n | input | 1 | Active-low reset |
| pfail | input | 1 | Power-fail reset state, forces strobes inactive |
| size_32k | input | 1 | 1: 32 KB SRAM, 0: 8 KB SRAM |
| bank2_sel | input | 1 | Redirect window data accesses to the second SRAM |
| part_load | input | 1 | Load the boundary register |
| part_val | input | 6 | New boundary in KB |
| acc_valid | input | 1 | Access present this cycle |
| acc_code | input | 1 | 1: code fetch, 0: data access |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 16 | Logical address |
| ce1_n | output | 1 | Chip select for the common SRAM, active low |
| ce2_n | output | 1 | Chip select for the data-only SRAM, active low |
| rw_n | output | 1 | Write strobe, active low |
| bw_addr | output | 15 | Byte-wide address, upper two bits inverted |
| route_bw | output | 1 | 1: byte-wide bus owns the access, 0: expanded bus |

## Verification
The decode is combinational from the access inputs, so a wrong window, size or bank term shows up in the same cycle. It appears as the wrong chip select or a wrong `route_bw` for that address. The only stored state is the boundary register. If it is corrupted, nothing changes on reads. It shows only on a later data write, where `rw_n` falls on the wrong side of the boundary. For that reason the boundary is probed with writes on both sides of each value loaded, one cycle after the load.

// File: rtl/nvbd_pkg.sv
package nvbd_pkg;

   // Active-high internal selects, before reset/power-fail forcing
   typedef struct packed {
      logic cs_main;
      logic cs_bank2;
      logic writable;
   } nvbd_sel_t;

endpackage

// File: rtl/nvbd_partition_reg.sv
module nvbd_partition_reg #(
   parameter int WIN_LG  = 15,
   parameter int GRAN_LG = 10,
   parameter int PART_W  = WIN_LG - GRAN_LG + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PART_W-1:0] load_val,
   output logic [PART_W-1:0] boundary
);

   localparam logic [PART_W-1:0] PART_MAX = PART_W'(1 << (WIN_LG - GRAN_LG));

   if (PART_W < WIN_LG - GRAN_LG + 1) begin : g_bad_w
      $error("nvbd_partition_reg: PART_W too narrow for the window");
   end

   logic [PART_W-1:0] next_val;

   always_comb begin
      next_val = (load_val > PART_MAX) ? PART_MAX : load_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    boundary <= PART_MAX;
      else if (load) boundary <= next_val;
   end

   assert_boundary_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      boundary <= PART_MAX);

   assert_boundary_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(boundary));

endmodule

// File: rtl/nvbd_addr_decode.sv
module nvbd_addr_decode
   import nvbd_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int WIN_LG  = 15,
   parameter int SMALL_LG = 13,
   parameter int GRAN_LG = 10,
   parameter int PART_W  = WIN_LG - GRAN_LG + 1
) (
   input  logic [ADDR_W-1:GRAN_LG] addr_hi,
   input  logic                    valid,
   input  logic                    is_code,
   input  logic                    size_big,
   input  logic                    bank2_en,
   input  logic [PART_W-1:0]       boundary,
   output nvbd_sel_t               sel
);

   localparam int SEG_W = WIN_LG - GRAN_LG;

   if (SMALL_LG < GRAN_LG || SMALL_LG > WIN_LG || WIN_LG >= ADDR_W) begin : g_bad_geom
      $error("nvbd_addr_decode: inconsistent window geometry");
   end

   logic in_window;
   logic small_fit;
   logic data_side;
   logic [PART_W-1:0] seg;

   assign in_window = (addr_hi[ADDR_W-1:WIN_LG] == '0);

   if (SMALL_LG < WIN_LG) begin : g_small
      assign small_fit = (addr_hi[WIN_LG-1:SMALL_LG] == '0);
   end else begin : g_nosmall
      assign small_fit = 1'b1;
   end

   assign seg       = {1'b0, addr_hi[WIN_LG-1:GRAN_LG]};
   assign data_side = (seg >= boundary);

   always_comb begin
      sel          = '0;
      sel.cs_bank2 = valid && in_window && !is_code && bank2_en;
      sel.cs_main  = valid && in_window && !sel.cs_bank2 && (size_big || small_fit);
      sel.writable = !is_code && (sel.cs_bank2 || (sel.cs_main && data_side));
   end

   // segment width sanity: boundary spans one more bit than segment index
   if (PART_W != SEG_W + 1) begin : g_bad_part
      $error("nvbd_addr_decode: PART_W must be window segment width plus one");
   end

endmodule

// File: rtl/nvbd_strobe_gen.sv
module nvbd_strobe_gen
   import nvbd_pkg::*;
(
   input  nvbd_sel_t sel,
   input  logic      write,
   input  logic      force_off,
   output logic      ce1_n,
   output logic      ce2_n,
   output logic      rw_n,
   output logic      route_bw
);

   always_comb begin
      if (force_off) begin
         ce1_n    = 1'b1;
         ce2_n    = 1'b1;
         rw_n     = 1'b1;
         route_bw = 1'b0;
      end else begin
         ce1_n    = !sel.cs_main;
         ce2_n    = !sel.cs_bank2;
         rw_n     = !(write && sel.writable);
         route_bw = sel.cs_main || sel.cs_bank2;
      end
   end

endmodule

// File: rtl/nvbd_decoder.sv
module nvbd_decoder
   import nvbd_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int WIN_LG   = 15,
   parameter int SMALL_LG = 13,
   parameter int GRAN_LG  = 10,
   parameter int INV_LO   = 13,
   parameter int PART_W   = WIN_LG - GRAN_LG + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pfail,
   input  logic              size_32k,
   input  logic              bank2_sel,
   input  logic              part_load,
   input  logic [PART_W-1:0] part_val,
   input  logic              acc_valid,
   input  logic              acc_code,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              ce1_n,
   output logic              ce2_n,
   output logic              rw_n,
   output logic [WIN_LG-1:0] bw_addr,
   output logic              route_bw
);

   if (INV_LO > WIN_LG) begin : g_bad_inv
      $error("nvbd_decoder: INV_LO outside the byte-wide address");
   end

   logic [PART_W-1:0] boundary;
   nvbd_sel_t         sel;

   nvbd_partition_reg #(
      .WIN_LG (WIN_LG),
      .GRAN_LG(GRAN_LG),
      .PART_W (PART_W)
   ) u_part (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (part_load),
      .load_val(part_val),
      .boundary(boundary)
   );

   nvbd_addr_decode #(
      .ADDR_W  (ADDR_W),
      .WIN_LG  (WIN_LG),
      .SMALL_LG(SMALL_LG),
      .GRAN_LG (GRAN_LG),
      .PART_W  (PART_W)
   ) u_dec (
      .addr_hi (acc_addr[ADDR_W-1:GRAN_LG]),
      .valid   (acc_valid),
      .is_code (acc_code),
      .size_big(size_32k),
      .bank2_en(bank2_sel),
      .boundary(boundary),
      .sel     (sel)
   );

   nvbd_strobe_gen u_stb (
      .sel      (sel),
      .write    (acc_write),
      .force_off(pfail || !rst_n),
      .ce1_n    (ce1_n),
      .ce2_n    (ce2_n),
      .rw_n     (rw_n),
      .route_bw (route_bw)
   );

   for (genvar i = 0; i < WIN_LG; i++) begin : g_baddr
      if (i >= INV_LO) begin : g_inv
         assign bw_addr[i] = ~acc_addr[i];
      end else begin : g_pass
         assign bw_addr[i] = acc_addr[i];
      end
   end

   assert_ce_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~ce1_n, ~ce2_n}) <= 1);

   assert_code_no_bank2_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_code |-> ce2_n);

   assert_code_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_code || !acc_write) |-> rw_n);

   assert_write_needs_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_n |-> (!ce1_n || !ce2_n));

   assert_pfail_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pfail |-> (ce1_n && ce2_n && rw_n && !route_bw));

   assert_upper_expanded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_addr[ADDR_W-1] |-> (!route_bw && ce1_n && ce2_n && rw_n));

   assert_idle_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (ce1_n && ce2_n && rw_n && !route_bw));

endmodule

// File: tb/tb_nvbd_decoder.sv
module tb_nvbd_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pfail = 1'b0;
   logic        size_32k = 1'b1;
   logic        bank2_sel = 1'b0;
   logic        part_load = 1'b0;
   logic [5:0]  part_val = '0;
   logic        acc_valid = 1'b0;
   logic        acc_code = 1'b0;
   logic        acc_write = 1'b0;
   logic [15:0] acc_addr = '0;
   logic        ce1_n, ce2_n, rw_n, route_bw;
   logic [14:0] bw_addr;

   int vectors = 0;
   int fails   = 0;

   always #2 clk = ~clk;

   nvbd_decoder dut (
      .clk(clk), .rst_n(rst_n), .pfail(pfail), .size_32k(size_32k),
      .bank2_sel(bank2_sel), .part_load(part_load), .part_val(part_val),
      .acc_valid(acc_valid), .acc_code(acc_code), .acc_write(acc_write),
      .acc_addr(acc_addr), .ce1_n(ce1_n), .ce2_n(ce2_n), .rw_n(rw_n),
      .bw_addr(bw_addr), .route_bw(route_bw)
   );

   // expected strobes packed as {ce1_n, ce2_n, rw_n, route_bw}
   task automatic expect_sel(string req, logic [3:0] exp);
      logic [3:0] got;
      got = {ce1_n, ce2_n, rw_n, route_bw};
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s addr=%h got {ce1_n,ce2_n,rw_n,route}=%b expected %b",
                  req, acc_addr, got, exp);
      end
   endtask

   task automatic drive(logic valid, logic code, logic wr, logic [15:0] a);
      @(negedge clk);
      acc_valid = valid;
      acc_code  = code;
      acc_write = wr;
      acc_addr  = a;
      #1;
   endtask

   task automatic set_part(logic [5:0] v);
      @(negedge clk);
      part_load = 1'b1;
      part_val  = v;
      @(negedge clk);
      part_load = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      expect_sel("R7 reset", 4'b1110);
      drive(1, 0, 1, 16'h1000);
      expect_sel("R7 reset access", 4'b1110);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8: boundary resets to all program, so a window data write is blocked
      drive(1, 0, 1, 16'h7000);
      expect_sel("R8 reset boundary", 4'b0111);
   endtask

   task automatic t_window;
      size_32k = 1'b1;
      drive(1, 0, 0, 16'h1234);
      expect_sel("R1 data read", 4'b0111);
      drive(1, 1, 0, 16'h7FFF);
      expect_sel("R1 code top", 4'b0111);
      drive(1, 1, 0, 16'h8000);
      expect_sel("R2 code upper", 4'b1110);
      drive(1, 0, 1, 16'hFFFF);
      expect_sel("R2 data write upper", 4'b1110);
      drive(0, 0, 1, 16'h0100);
      expect_sel("R10 no access", 4'b1110);
   endtask

   task automatic t_addr;
      drive(1, 0, 0, 16'h1234);
      vectors++;
      if (bw_addr !== 15'h7234) begin
         fails++;
         $display("FAIL R6 bw_addr=%h expected %h", bw_addr, 15'h7234);
      end
      drive(1, 1, 0, 16'h5ABC);
      vectors++;
      if (bw_addr !== 15'h3ABC) begin
         fails++;
         $display("FAIL R6 bw_addr=%h expected %h", bw_addr, 15'h3ABC);
      end
   endtask

   task automatic t_size;
      size_32k = 1'b0;
      drive(1, 0, 0, 16'h1FFF);
      expect_sel("R3 small last", 4'b0111);
      drive(1, 0, 0, 16'h2000);
      expect_sel("R3 small beyond data", 4'b1110);
      drive(1, 1, 0, 16'h6000);
      expect_sel("R3 small beyond code", 4'b1110);
      size_32k = 1'b1;
   endtask

   task automatic t_partition;
      set_part(6'd8);
      drive(1, 0, 1, 16'h1FFF);
      expect_sel("R5 below boundary", 4'b0111);
      drive(1, 0, 1, 16'h2000);
      expect_sel("R5 at boundary", 4'b0101);
      drive(1, 1, 1, 16'h3000);
      expect_sel("R5 code write", 4'b0111);
      drive(1, 0, 0, 16'h3000);
      expect_sel("R5 data read", 4'b0111);
      set_part(6'd40);
      drive(1, 0, 1, 16'h7C00);
      expect_sel("R8 saturate", 4'b0111);
      set_part(6'd0);
      drive(1, 0, 1, 16'h0000);
      expect_sel("R8 all data", 4'b0101);
   endtask

   task automatic t_bank2;
      set_part(6'd32);
      bank2_sel = 1'b1;
      drive(1, 0, 1, 16'h0100);
      expect_sel("R9 bank2 write", 4'b1001);
      size_32k = 1'b0;
      drive(1, 0, 0, 16'h6000);
      expect_sel("R4 bank2 small mode", 4'b1011);
      size_32k = 1'b1;
      drive(1, 1, 0, 16'h0100);
      expect_sel("R4 code stays ce1", 4'b0111);
      drive(1, 0, 0, 16'h9000);
      expect_sel("R4 bank2 upper", 4'b1110);
      bank2_sel = 1'b0;
   endtask

   task automatic t_pfail;
      set_part(6'd0);
      pfail = 1'b1;
      drive(1, 0, 1, 16'h2000);
      expect_sel("R7 power fail", 4'b1110);
      pfail = 1'b0;
      #1;
      expect_sel("R7 power back", 4'b0101);
   endtask

   initial begin
      t_reset();
      t_window();
      t_addr();
      t_size();
      t_partition();
      t_bank2();
      t_pfail();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule